// File: doc/BRIEF.md
# Pending-Transaction Table with Parallel Lookup

This block holds the coherence transactions a private cache controller still has in flight. It is a small register table with one entry for each possible outstanding transaction. Every hardware thread may have one ordinary miss and one eviction pending at once, so the depth is fixed at twice the thread count. Each entry records its occupancy, the full block address, the requesting thread, a flag that asks for the thread to be woken when the transaction ends, the transient coherence state, a flag that marks a pre-booked eviction, and a count of acknowledgements still owed.

Several request classes are scheduled in parallel, and each class has its own lookup port. A port takes a set index and reports in the same cycle whether any occupied entry covers that set. It also returns which entry matched and that entry's fields. A single write port fills, changes or empties the entry at a given index. A separate output names the lowest empty entry, which a requester uses when it books a new transaction. A build-time switch decides whether a lookup made in the cycle of a write sees the old entry or the new one.

Top module: `miss_status_table`

## Requirements
- R1: After reset every entry is empty: no port hits, `free_any` is 1 and `free_idx` is 0.
- R2: An entry changes only at a clock edge where `wr_en` is 1 and `wr_idx` names it. All fields are then replaced by the `wr_*` inputs. With `wr_en` at 0, no write field has any effect.
- R3: A port hits when an occupied entry's set index equals the port's `lk_set`. The set index is the low `SET_W` bits of the stored address. On a hit the port returns that entry's index, address, thread, wakeup flag, state, eviction flag and ack count.
- R4: When several occupied entries share the looked-up set, the port reports the one with the lowest index.
- R5: On a miss the port drives its index and all of its field outputs to 0.
- R6: With `WRITE_FIRST` = 0, lookups see only stored entries. A write first becomes visible to lookups in the cycle after its edge.
- R7: With `WRITE_FIRST` = 1, a lookup in the same cycle as a write sees the written values for the entry at `wr_idx`. This includes a write that empties the entry.
- R8: Emptying an entry is a write with `wr_valid` = 0. From then on the entry no longer hits, and the next matching entry with a higher index is reported in its place.
- R9: `free_idx` is the lowest index whose stored entry is empty. `free_any` is 0 only when every entry is occupied, and `free_idx` is then 0. Both follow the stored state, whatever the value of `WRITE_FIRST`.
- R10: The table holds 2 × `THREADS` entries. All of them can be occupied at the same time, and each can be found by lookup.
- R11: The lookup ports are independent: each answers its own `lk_set` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | IDX_W | Entry to write |
| wr_valid | input | 1 | New occupancy bit (0 empties the entry) |
| wr_addr | input | ADDR_W | New block address; set index in the low SET_W bits |
| wr_thread | input | THREAD_W | New requesting thread |
| wr_wake | input | 1 | New wakeup flag |
| wr_state | input | STATE_W | New coherence state |
| wr_evict | input | 1 | New eviction-booked flag |
| wr_acks | input | ACK_W | New outstanding ack count |
| lk_set | input | NPORTS × SET_W | Set index looked up on each port |
| lk_hit | output | NPORTS | Per-port hit |
| lk_idx | output | NPORTS × IDX_W | Matching entry index |
| lk_addr | output | NPORTS × ADDR_W | Matching entry address |
| lk_thread | output | NPORTS × THREAD_W | Matching entry thread |
| lk_wake | output | NPORTS | Matching entry wakeup flag |
| lk_state | output | NPORTS × STATE_W | Matching entry state |
| lk_evict | output | NPORTS | Matching entry eviction flag |
| lk_acks | output | NPORTS × ACK_W | Matching entry ack count |
| free_idx | output | IDX_W | Lowest empty entry |
| free_any | output | 1 | At least one entry is empty |

## Verification
The hardest case to reach is a write and a lookup of the same set in the same cycle, because that is the only place where the two ordering variants differ. The bench drives one stimulus into two copies of the table, one per ordering. It then places writes, including ones that empty an entry, in the very cycle of a matching lookup. The full-table case is reached by filling every index and then freeing a middle entry, so the free index moves somewhere other than entry 0. A random phase confined to a few sets makes shared-set matches and lowest-index resolution frequent.

// File: rtl/mst_pkg.sv
package mst_pkg;

    // Upper bound on table depth supported by the priority helpers.
    localparam int MST_MAX_DEPTH = 64;

    // Position of the lowest set bit; 0 when the vector is empty.
    function automatic int unsigned mst_lowest(input logic [MST_MAX_DEPTH-1:0] v);
        int unsigned pos;
        pos = 0;
        for (int i = MST_MAX_DEPTH - 1; i >= 0; i--) begin
            if (v[i]) pos = i;
        end
        return pos;
    endfunction

endpackage

// File: rtl/mst_entry_bank.sv
module mst_entry_bank #(
    parameter int DEPTH       = 8,
    parameter int IDX_W       = 3,
    parameter int ADDR_W      = 16,
    parameter int THREAD_W    = 2,
    parameter int STATE_W     = 3,
    parameter int ACK_W       = 4,
    parameter bit WRITE_FIRST = 1'b0
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [IDX_W-1:0]                 wr_idx,
    input  logic                             wr_valid,
    input  logic [ADDR_W-1:0]                wr_addr,
    input  logic [THREAD_W-1:0]              wr_thread,
    input  logic                             wr_wake,
    input  logic [STATE_W-1:0]               wr_state,
    input  logic                             wr_evict,
    input  logic [ACK_W-1:0]                 wr_acks,
    output logic [DEPTH-1:0]                 st_valid,
    output logic [DEPTH-1:0]                 vw_valid,
    output logic [DEPTH-1:0][ADDR_W-1:0]     vw_addr,
    output logic [DEPTH-1:0][THREAD_W-1:0]   vw_thread,
    output logic [DEPTH-1:0]                 vw_wake,
    output logic [DEPTH-1:0][STATE_W-1:0]    vw_state,
    output logic [DEPTH-1:0]                 vw_evict,
    output logic [DEPTH-1:0][ACK_W-1:0]      vw_acks
);

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        logic                sel;
        logic                r_valid;
        logic [ADDR_W-1:0]   r_addr;
        logic [THREAD_W-1:0] r_thread;
        logic                r_wake;
        logic [STATE_W-1:0]  r_state;
        logic                r_evict;
        logic [ACK_W-1:0]    r_acks;

        assign sel = wr_en && (wr_idx == IDX_W'(e));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                r_valid  <= 1'b0;
                r_addr   <= '0;
                r_thread <= '0;
                r_wake   <= 1'b0;
                r_state  <= '0;
                r_evict  <= 1'b0;
                r_acks   <= '0;
            end else if (sel) begin
                r_valid  <= wr_valid;
                r_addr   <= wr_addr;
                r_thread <= wr_thread;
                r_wake   <= wr_wake;
                r_state  <= wr_state;
                r_evict  <= wr_evict;
                r_acks   <= wr_acks;
            end
        end

        assign st_valid[e] = r_valid;

        if (WRITE_FIRST) begin : g_bypass
            assign vw_valid[e]  = sel ? wr_valid  : r_valid;
            assign vw_addr[e]   = sel ? wr_addr   : r_addr;
            assign vw_thread[e] = sel ? wr_thread : r_thread;
            assign vw_wake[e]   = sel ? wr_wake   : r_wake;
            assign vw_state[e]  = sel ? wr_state  : r_state;
            assign vw_evict[e]  = sel ? wr_evict  : r_evict;
            assign vw_acks[e]   = sel ? wr_acks   : r_acks;
        end else begin : g_stored
            assign vw_valid[e]  = r_valid;
            assign vw_addr[e]   = r_addr;
            assign vw_thread[e] = r_thread;
            assign vw_wake[e]   = r_wake;
            assign vw_state[e]  = r_state;
            assign vw_evict[e]  = r_evict;
            assign vw_acks[e]   = r_acks;
        end
    end

endmodule

// File: rtl/mst_lookup_port.sv
module mst_lookup_port
    import mst_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int IDX_W    = 3,
    parameter int SET_W    = 6,
    parameter int ADDR_W   = 16,
    parameter int THREAD_W = 2,
    parameter int STATE_W  = 3,
    parameter int ACK_W    = 4
) (
    input  logic [SET_W-1:0]                 key,
    input  logic [DEPTH-1:0]                 vw_valid,
    input  logic [DEPTH-1:0][ADDR_W-1:0]     vw_addr,
    input  logic [DEPTH-1:0][THREAD_W-1:0]   vw_thread,
    input  logic [DEPTH-1:0]                 vw_wake,
    input  logic [DEPTH-1:0][STATE_W-1:0]    vw_state,
    input  logic [DEPTH-1:0]                 vw_evict,
    input  logic [DEPTH-1:0][ACK_W-1:0]      vw_acks,
    output logic                             hit,
    output logic [IDX_W-1:0]                 idx,
    output logic [ADDR_W-1:0]                addr,
    output logic [THREAD_W-1:0]              thread,
    output logic                             wake,
    output logic [STATE_W-1:0]               state,
    output logic                             evict,
    output logic [ACK_W-1:0]                 acks
);

    logic [MST_MAX_DEPTH-1:0] match;

    always_comb begin
        match = '0;
        for (int i = 0; i < DEPTH; i++) begin
            match[i] = vw_valid[i] && (vw_addr[i][SET_W-1:0] == key);
        end
    end

    always_comb begin
        hit    = |match;
        idx    = '0;
        addr   = '0;
        thread = '0;
        wake   = 1'b0;
        state  = '0;
        evict  = 1'b0;
        acks   = '0;
        if (hit) begin
            idx    = IDX_W'(mst_lowest(match));
            addr   = vw_addr[idx];
            thread = vw_thread[idx];
            wake   = vw_wake[idx];
            state  = vw_state[idx];
            evict  = vw_evict[idx];
            acks   = vw_acks[idx];
        end
    end

endmodule

// File: rtl/mst_free_finder.sv
module mst_free_finder
    import mst_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3
) (
    input  logic [DEPTH-1:0] st_valid,
    output logic [IDX_W-1:0] free_idx,
    output logic             free_any
);

    logic [MST_MAX_DEPTH-1:0] empty;

    always_comb begin
        empty = '0;
        empty[DEPTH-1:0] = ~st_valid;
        free_any = |empty;
        free_idx = free_any ? IDX_W'(mst_lowest(empty)) : '0;
    end

endmodule

// File: rtl/miss_status_table.sv
module miss_status_table #(
    parameter int THREADS     = 4,
    parameter int NPORTS      = 3,
    parameter int ADDR_W      = 16,
    parameter int SET_W       = 6,
    parameter int STATE_W     = 3,
    parameter int ACK_W       = 4,
    parameter bit WRITE_FIRST = 1'b0,
    localparam int DEPTH      = 2 * THREADS,
    localparam int IDX_W      = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int THREAD_W   = (THREADS > 1) ? $clog2(THREADS) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  logic                              wr_valid,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  logic [THREAD_W-1:0]               wr_thread,
    input  logic                              wr_wake,
    input  logic [STATE_W-1:0]                wr_state,
    input  logic                              wr_evict,
    input  logic [ACK_W-1:0]                  wr_acks,
    input  logic [NPORTS-1:0][SET_W-1:0]      lk_set,
    output logic [NPORTS-1:0]                 lk_hit,
    output logic [NPORTS-1:0][IDX_W-1:0]      lk_idx,
    output logic [NPORTS-1:0][ADDR_W-1:0]     lk_addr,
    output logic [NPORTS-1:0][THREAD_W-1:0]   lk_thread,
    output logic [NPORTS-1:0]                 lk_wake,
    output logic [NPORTS-1:0][STATE_W-1:0]    lk_state,
    output logic [NPORTS-1:0]                 lk_evict,
    output logic [NPORTS-1:0][ACK_W-1:0]      lk_acks,
    output logic [IDX_W-1:0]                  free_idx,
    output logic                              free_any
);

    logic [DEPTH-1:0]               st_valid;
    logic [DEPTH-1:0]               vw_valid;
    logic [DEPTH-1:0][ADDR_W-1:0]   vw_addr;
    logic [DEPTH-1:0][THREAD_W-1:0] vw_thread;
    logic [DEPTH-1:0]               vw_wake;
    logic [DEPTH-1:0][STATE_W-1:0]  vw_state;
    logic [DEPTH-1:0]               vw_evict;
    logic [DEPTH-1:0][ACK_W-1:0]    vw_acks;

    mst_entry_bank #(
        .DEPTH(DEPTH), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .THREAD_W(THREAD_W),
        .STATE_W(STATE_W), .ACK_W(ACK_W), .WRITE_FIRST(WRITE_FIRST)
    ) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_thread(wr_thread), .wr_wake(wr_wake), .wr_state(wr_state),
        .wr_evict(wr_evict), .wr_acks(wr_acks),
        .st_valid(st_valid), .vw_valid(vw_valid), .vw_addr(vw_addr),
        .vw_thread(vw_thread), .vw_wake(vw_wake), .vw_state(vw_state),
        .vw_evict(vw_evict), .vw_acks(vw_acks)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        mst_lookup_port #(
            .DEPTH(DEPTH), .IDX_W(IDX_W), .SET_W(SET_W), .ADDR_W(ADDR_W),
            .THREAD_W(THREAD_W), .STATE_W(STATE_W), .ACK_W(ACK_W)
        ) u_lookup (
            .key(lk_set[p]),
            .vw_valid(vw_valid), .vw_addr(vw_addr), .vw_thread(vw_thread),
            .vw_wake(vw_wake), .vw_state(vw_state), .vw_evict(vw_evict),
            .vw_acks(vw_acks),
            .hit(lk_hit[p]), .idx(lk_idx[p]), .addr(lk_addr[p]),
            .thread(lk_thread[p]), .wake(lk_wake[p]), .state(lk_state[p]),
            .evict(lk_evict[p]), .acks(lk_acks[p])
        );
    end

    mst_free_finder #(
        .DEPTH(DEPTH), .IDX_W(IDX_W)
    ) u_free (
        .st_valid(st_valid), .free_idx(free_idx), .free_any(free_any)
    );

endmodule

// File: rtl/mst_checker.sv
module mst_checker #(
    parameter int NPORTS      = 3,
    parameter int ADDR_W      = 16,
    parameter int SET_W       = 6,
    parameter int IDX_W       = 3,
    parameter bit WRITE_FIRST = 1'b0
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          wr_en,
    input logic [IDX_W-1:0]              wr_idx,
    input logic                          wr_valid,
    input logic [ADDR_W-1:0]             wr_addr,
    input logic [NPORTS-1:0][SET_W-1:0]  lk_set,
    input logic [NPORTS-1:0]             lk_hit,
    input logic [NPORTS-1:0][IDX_W-1:0]  lk_idx,
    input logic [NPORTS-1:0][ADDR_W-1:0] lk_addr,
    input logic [IDX_W-1:0]              free_idx,
    input logic                          free_any
);

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rst_n) && !wr_en) |-> ((lk_hit == '0) && free_any && (free_idx == '0))); // R1

    for (genvar p = 0; p < NPORTS; p++) begin : g_chk
        AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            !lk_hit[p] |-> ((lk_idx[p] == '0) && (lk_addr[p] == '0))); // R5

        AST_HIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
            lk_hit[p] |-> (lk_addr[p][SET_W-1:0] == lk_set[p])); // R3

        if (WRITE_FIRST) begin : g_wf
            AST_BYPASS_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_valid && (wr_addr[SET_W-1:0] == lk_set[p])) |-> lk_hit[p]); // R7

            AST_DEALLOC_GONE: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && !wr_valid && lk_hit[p]) |-> (lk_idx[p] != wr_idx)); // R8
        end else begin : g_rf
            AST_LATE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(wr_en && wr_valid) &&
                 (lk_set[p] == $past(wr_addr[SET_W-1:0]))) |-> lk_hit[p]); // R6
        end
    end

endmodule

bind miss_status_table mst_checker #(
    .NPORTS(NPORTS), .ADDR_W(ADDR_W), .SET_W(SET_W), .IDX_W(IDX_W),
    .WRITE_FIRST(WRITE_FIRST)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .lk_set(lk_set),
    .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_addr(lk_addr),
    .free_idx(free_idx), .free_any(free_any)
);

// File: tb/sim_miss_status_table.sv
`timescale 1ns/1ps
module sim_miss_status_table;

    localparam int THREADS  = 4;
    localparam int NPORTS   = 3;
    localparam int ADDR_W   = 16;
    localparam int SET_W    = 6;
    localparam int STATE_W  = 3;
    localparam int ACK_W    = 4;
    localparam int DEPTH    = 2 * THREADS;
    localparam int IDX_W    = $clog2(DEPTH);
    localparam int THREAD_W = $clog2(THREADS);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic                         wr_en = 1'b0;
    logic [IDX_W-1:0]             wr_idx = '0;
    logic                         wr_valid = 1'b0;
    logic [ADDR_W-1:0]            wr_addr = '0;
    logic [THREAD_W-1:0]          wr_thread = '0;
    logic                         wr_wake = 1'b0;
    logic [STATE_W-1:0]           wr_state = '0;
    logic                         wr_evict = 1'b0;
    logic [ACK_W-1:0]             wr_acks = '0;
    logic [NPORTS-1:0][SET_W-1:0] lk_set = '0;

    logic [NPORTS-1:0]               o_hit   [2];
    logic [NPORTS-1:0][IDX_W-1:0]    o_idx   [2];
    logic [NPORTS-1:0][ADDR_W-1:0]   o_addr  [2];
    logic [NPORTS-1:0][THREAD_W-1:0] o_thr   [2];
    logic [NPORTS-1:0]               o_wake  [2];
    logic [NPORTS-1:0][STATE_W-1:0]  o_state [2];
    logic [NPORTS-1:0]               o_evict [2];
    logic [NPORTS-1:0][ACK_W-1:0]    o_acks  [2];
    logic [IDX_W-1:0]                o_fidx  [2];
    logic                            o_fany  [2];

    miss_status_table #(.THREADS(THREADS), .NPORTS(NPORTS), .ADDR_W(ADDR_W),
        .SET_W(SET_W), .STATE_W(STATE_W), .ACK_W(ACK_W), .WRITE_FIRST(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_thread(wr_thread), .wr_wake(wr_wake), .wr_state(wr_state),
        .wr_evict(wr_evict), .wr_acks(wr_acks), .lk_set(lk_set),
        .lk_hit(o_hit[0]), .lk_idx(o_idx[0]), .lk_addr(o_addr[0]), .lk_thread(o_thr[0]),
        .lk_wake(o_wake[0]), .lk_state(o_state[0]), .lk_evict(o_evict[0]),
        .lk_acks(o_acks[0]), .free_idx(o_fidx[0]), .free_any(o_fany[0]));

    miss_status_table #(.THREADS(THREADS), .NPORTS(NPORTS), .ADDR_W(ADDR_W),
        .SET_W(SET_W), .STATE_W(STATE_W), .ACK_W(ACK_W), .WRITE_FIRST(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_thread(wr_thread), .wr_wake(wr_wake), .wr_state(wr_state),
        .wr_evict(wr_evict), .wr_acks(wr_acks), .lk_set(lk_set),
        .lk_hit(o_hit[1]), .lk_idx(o_idx[1]), .lk_addr(o_addr[1]), .lk_thread(o_thr[1]),
        .lk_wake(o_wake[1]), .lk_state(o_state[1]), .lk_evict(o_evict[1]),
        .lk_acks(o_acks[1]), .free_idx(o_fidx[1]), .free_any(o_fany[1]));

    // Behavioural reference: the stored contents of the table.
    bit          m_valid [DEPTH];
    int unsigned m_addr  [DEPTH];
    int unsigned m_thr   [DEPTH];
    int unsigned m_wake  [DEPTH];
    int unsigned m_state [DEPTH];
    int unsigned m_evict [DEPTH];
    int unsigned m_acks  [DEPTH];

    int    n_cmp = 0;
    int    n_bad = 0;
    string phase = "R1";
    bit    finished = 1'b0;

    task automatic chk(input string req, input int unsigned got, input int unsigned exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    task automatic cmp_dut(input int d);
        for (int p = 0; p < NPORTS; p++) begin
            int unsigned eh, ei, ea, et, ew, es, ee, ek;
            eh = 0; ei = 0; ea = 0; et = 0; ew = 0; es = 0; ee = 0; ek = 0;
            for (int i = DEPTH - 1; i >= 0; i--) begin
                bit v;
                int unsigned a, t, w, s, e, k;
                v = m_valid[i]; a = m_addr[i]; t = m_thr[i]; w = m_wake[i];
                s = m_state[i]; e = m_evict[i]; k = m_acks[i];
                if (d == 1 && wr_en && wr_idx == IDX_W'(i)) begin
                    v = wr_valid; a = wr_addr; t = wr_thread; w = wr_wake;
                    s = wr_state; e = wr_evict; k = wr_acks;
                end
                if (v && (a % (1 << SET_W)) == lk_set[p]) begin
                    eh = 1; ei = i; ea = a; et = t; ew = w; es = s; ee = e; ek = k;
                end
            end
            n_cmp++;
            if (o_hit[d][p] != eh || o_idx[d][p] != ei || o_addr[d][p] != ea ||
                o_thr[d][p] != et || o_wake[d][p] != ew || o_state[d][p] != es ||
                o_evict[d][p] != ee || o_acks[d][p] != ek) begin
                n_bad++;
                $display("FAIL %s u%0d port%0d: got hit=%0d idx=%0d addr=%h thr=%0d wk=%0d st=%0d ev=%0d ack=%0d expected hit=%0d idx=%0d addr=%h thr=%0d wk=%0d st=%0d ev=%0d ack=%0d",
                    phase, d, p, o_hit[d][p], o_idx[d][p], o_addr[d][p], o_thr[d][p],
                    o_wake[d][p], o_state[d][p], o_evict[d][p], o_acks[d][p],
                    eh, ei, ea, et, ew, es, ee, ek);
            end
        end
        begin
            int unsigned fi, fa;
            fi = 0; fa = 0;
            for (int i = DEPTH - 1; i >= 0; i--) if (!m_valid[i]) begin fi = i; fa = 1; end
            n_cmp++;
            if (o_fidx[d] != fi || o_fany[d] != fa) begin
                n_bad++;
                $display("FAIL R9 (%s) u%0d: got free_idx=%0d free_any=%0d expected free_idx=%0d free_any=%0d",
                    phase, d, o_fidx[d], o_fany[d], fi, fa);
            end
        end
    endtask

    // Compare on every clock, then advance the reference at the edge.
    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            m_valid[i] = 0; m_addr[i] = 0; m_thr[i] = 0; m_wake[i] = 0;
            m_state[i] = 0; m_evict[i] = 0; m_acks[i] = 0;
        end
        forever begin
            @(negedge clk);
            #1;
            if (rst_n) begin
                cmp_dut(0);
                cmp_dut(1);
            end
            @(posedge clk);
            if (rst_n && wr_en) begin
                m_valid[wr_idx] = wr_valid;  m_addr[wr_idx]  = wr_addr;
                m_thr[wr_idx]   = wr_thread; m_wake[wr_idx]  = wr_wake;
                m_state[wr_idx] = wr_state;  m_evict[wr_idx] = wr_evict;
                m_acks[wr_idx]  = wr_acks;
            end
        end
    end

    task automatic wr(input int i, input bit v, input int tag, input int s,
                      input int t, input int st, input int ack);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = IDX_W'(i); wr_valid = v;
        wr_addr = ADDR_W'((tag << SET_W) | s); wr_thread = THREAD_W'(t);
        wr_wake = t[0]; wr_state = STATE_W'(st); wr_evict = ~v ? 1'b0 : st[0];
        wr_acks = ACK_W'(ack);
    endtask

    task automatic nowr();
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic lk(input int a, input int b, input int c);
        lk_set[0] = SET_W'(a); lk_set[1] = SET_W'(b); lk_set[2] = SET_W'(c);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        phase = "R1";
        nowr(); lk(0, 1, 2); #2;
        chk("R1 hits", o_hit[0] | o_hit[1], 0);
        chk("R1 free_any", o_fany[0], 1);
        chk("R1 free_idx", o_fidx[1], 0);

        phase = "R2";
        wr(0, 1, 'h11, 1, 1, 2, 3); lk(1, 1, 1);
        wr(1, 1, 'h22, 2, 2, 4, 0);
        wr(2, 1, 'h33, 3, 3, 5, 15);
        phase = "R11";
        nowr(); lk(1, 2, 3); #2;
        chk("R11 hits", o_hit[0], 3'b111);
        chk("R11 port2 idx", o_idx[0][2], 2);
        chk("R3 port1 addr", o_addr[0][1], (('h22) << SET_W) | 2);
        chk("R3 port2 acks", o_acks[1][2], 15);

        phase = "R4";
        wr(5, 1, 'h55, 9, 0, 1, 1);
        wr(3, 1, 'h44, 9, 1, 6, 2);
        nowr(); lk(9, 9, 9); #2;
        chk("R4 lowest idx", o_idx[0][0], 3);

        phase = "R6/R7";
        wr(4, 1, 'h66, 12, 2, 3, 7); lk(12, 12, 12); #2;
        chk("R6 old view", o_hit[0][0], 0);
        chk("R7 bypass hit", o_hit[1][1], 1);
        chk("R7 bypass idx", o_idx[1][1], 4);
        nowr(); #2;
        chk("R6 visible next", o_idx[0][2], 4);

        phase = "R8";
        wr(3, 0, 'h44, 9, 1, 6, 2); lk(9, 9, 9); #2;
        chk("R8 bypass dealloc", o_idx[1][0], 5);
        chk("R6 still old", o_idx[0][0], 3);
        nowr(); #2;
        chk("R8 dealloc", o_idx[0][0], 5);

        phase = "R2";
        @(negedge clk);
        wr_en = 1'b0; wr_idx = 3'd5; wr_valid = 1'b0; wr_addr = 16'hFFFF; #2;
        nowr(); #2;
        chk("R2 disabled write", o_idx[0][1], 5);
        phase = "R9";
        chk("R9 lowest free", o_fidx[0], 3);

        phase = "R10";
        wr(3, 1, 'h01, 20, 0, 2, 1);
        wr(6, 1, 'h02, 21, 1, 2, 1);
        wr(7, 1, 'h03, 22, 2, 2, 1);
        nowr(); lk(20, 21, 22); #2;
        chk("R10 full free_any", o_fany[0], 0);
        chk("R10 full free_idx", o_fidx[1], 0);
        chk("R10 last entry", o_idx[0][2], 7);

        phase = "R9";
        wr(6, 0, 0, 0, 0, 0, 0);
        nowr(); #2;
        chk("R9 freed middle", o_fidx[0], 6);
        chk("R9 stored only", o_fidx[1], 6);

        phase = "R5";
        lk(40, 41, 42); #2;
        chk("R5 miss", o_hit[0] | o_hit[1], 0);
        chk("R5 zero addr", o_addr[1][0], 0);

        phase = "R3";
        for (int n = 0; n < 600; n++) begin
            if ($urandom % 3 != 0)
                wr($urandom % DEPTH, ($urandom % 4) != 0, $urandom % 1024,
                   $urandom % 6, $urandom % 4, $urandom % 8, $urandom % 16);
            else
                nowr();
            lk($urandom % 6, $urandom % 6, $urandom % 6);
        end
        nowr();
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule